// File: doc/BRIEF.md
# Gated Timer/Counter

A 16-bit timer/counter with a selectable operating mode. It counts or measures activity on an event clock input (CLK), or produces timed pulses on an output (OUT), under the control of a GATE input and an UPDOWN direction input. Every input is sampled in the system clock domain. Edges on CLK and GATE are found by comparing each sample with the one taken in the previous system cycle. A small write-only register port sets the mode, the input and output polarities, the initial count, the pulse delay and the pulse width. Separate software-start and software-reset strobes control the run state.

Software first writes the configuration while the block is halted, then pulses start. In the counting modes the count register follows CLK edges. In the pulse modes the same register counts down the delay phase and then the width phase. A sticky done flag marks a finished measurement or a finished one-shot pulse.

Top module: `gated_timer`

## Requirements
- R1: After reset, count_o is 0, out_o is 0 and done_o is 0. Every configuration register is cleared, so the mode is 0 and all polarities are at their defaults.
- R2: Nothing counts and OUT stays put until a start. A software-reset halts the block, clears done and loads the initial count. When start and software-reset arrive in the same cycle, the reset wins.
- R3: Mode code 0, event counting. Each active CLK edge seen while GATE is active changes the count by one: up when updown_i is 1, down when it is 0. The count wraps modulo 2^16, so one step down from 0 gives 0xFFFF.
- R4: Mode code 1, pulse-width measurement. Start loads the initial count, which then counts as in R3. When GATE goes from active to inactive, done sets and the count freezes until the next start or software-reset.
- R5: Mode code 2, single gated pulse. Start loads the delay. OUT stays inactive for the delay count of active CLK edges, then is active for the width count of edges. After that done sets and OUT returns to inactive. The count moves only while GATE is active. A delay or width of 0 behaves as 1.
- R6: Mode code 3, single triggered pulse. After start, the first active GATE edge begins one delayed pulse, timed as in R5, whatever GATE does afterwards. When the pulse ends, done sets and later GATE edges are ignored.
- R7: Mode code 4, retriggered pulse. Every active GATE edge that arrives while no pulse is pending begins a delayed pulse. GATE edges that arrive during the delay or the width are ignored. done never sets in this mode.
- R8: Mode code 5, continuous pulses. After start, delay and width phases alternate without end. While GATE is inactive, both the count and OUT hold.
- R9: Control word bit 3 makes the falling CLK edge the active one, bit 4 makes GATE active low, and bit 5 inverts out_o. The mode code sits in bits 2:0.
- R10: Register select 0 writes the control word, 1 the initial count, 2 the delay and 3 the width. A write takes effect on the following cycle. count_o, out_o and done_o change one cycle after the input edge that causes the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ev_clk_i | input | 1 | Event clock to be counted (CLK) |
| gate_i | input | 1 | Gate / trigger input |
| updown_i | input | 1 | Count direction in modes 0 and 1, 1 = up |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select |
| wr_data_i | input | 16 | Register write data |
| sw_start_i | input | 1 | Software start strobe |
| sw_reset_i | input | 1 | Software reset strobe |
| count_o | output | 16 | Current count |
| out_o | output | 1 | Pulse output after polarity |
| done_o | output | 1 | Measurement or one-shot finished |

## Verification
The assertions assume that ev_clk_i and gate_i are synchronous to clk and hold each level for at least one system cycle, so that every edge is seen exactly once. They also assume that configuration writes happen only while the block is halted and never in the same cycle as a start or software-reset. The stimulus keeps to these rules: it changes CLK and GATE one level per system cycle, drives them just after a clock edge, and rewrites the registers only between runs, after a software-reset. Each scenario is compared cycle by cycle against a behavioural model of the mode it is exercising.

// File: rtl/gtc_pkg.sv
package gtc_pkg;
   typedef enum logic [2:0] {
      M_EVENT  = 3'd0,
      M_MEAS   = 3'd1,
      M_GATED  = 3'd2,
      M_TRIG   = 3'd3,
      M_RETRIG = 3'd4,
      M_CONT   = 3'd5
   } mode_e;

   typedef enum logic [2:0] {
      PH_IDLE, PH_WAIT, PH_DELAY, PH_WIDTH, PH_FINAL
   } phase_e;

   typedef struct packed {
      logic  out_inv;
      logic  gate_low;
      logic  clk_fall;
      mode_e mode;
   } ctrl_t;

   localparam int CTRL_BITS = $bits(ctrl_t);
   localparam logic [1:0] SEL_CTRL  = 2'd0;
   localparam logic [1:0] SEL_INIT  = 2'd1;
   localparam logic [1:0] SEL_DELAY = 2'd2;
   localparam logic [1:0] SEL_WIDTH = 2'd3;
endpackage

// File: rtl/gtc_cond.sv
module gtc_cond #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] sig_i,
   input  logic [N-1:0] inv_i,
   output logic [N-1:0] lvl_o,
   output logic [N-1:0] rise_o,
   output logic [N-1:0] fall_o
);
   logic [N-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= lvl_o;
   end

   for (genvar g = 0; g < N; g++) begin : g_bit
      assign lvl_o[g]  = sig_i[g] ^ inv_i[g];
      assign rise_o[g] = lvl_o[g] & ~prev_q[g];
      assign fall_o[g] = ~lvl_o[g] & prev_q[g];
   end
endmodule

// File: rtl/gtc_regs.sv
module gtc_regs
   import gtc_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en_i,
   input  logic [1:0]   wr_sel_i,
   input  logic [W-1:0] wr_data_i,
   output ctrl_t        ctrl_o,
   output logic [W-1:0] init_o,
   output logic [W-1:0] dly_o,
   output logic [W-1:0] wid_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_o <= '0;
         init_o <= '0;
         dly_o  <= '0;
         wid_o  <= '0;
      end else if (wr_en_i) begin
         case (wr_sel_i)
            SEL_CTRL:  ctrl_o <= ctrl_t'(wr_data_i[CTRL_BITS-1:0]);
            SEL_INIT:  init_o <= wr_data_i;
            SEL_DELAY: dly_o  <= wr_data_i;
            default:   wid_o  <= wr_data_i;
         endcase
      end
   end
endmodule

// File: rtl/gtc_core.sv
module gtc_core
   import gtc_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  ctrl_t        ctrl_i,
   input  logic [W-1:0] init_i,
   input  logic [W-1:0] dly_i,
   input  logic [W-1:0] wid_i,
   input  logic         clk_edge_i,
   input  logic         gate_lvl_i,
   input  logic         gate_rise_i,
   input  logic         gate_fall_i,
   input  logic         updown_i,
   input  logic         sw_start_i,
   input  logic         sw_reset_i,
   output logic [W-1:0] cnt_o,
   output logic         out_lvl_o,
   output logic         done_o
);
   localparam logic [W-1:0] ONE = W'(1);

   logic [W-1:0] cnt_q, cnt_n;
   phase_e       ph_q, ph_n;
   logic         run_q, run_n, done_q, done_n, out_q, out_n, adv;

   always_comb begin
      cnt_n  = cnt_q;
      ph_n   = ph_q;
      run_n  = run_q;
      done_n = done_q;
      out_n  = out_q;
      adv    = 1'b0;
      if (sw_reset_i) begin
         run_n  = 1'b0;
         done_n = 1'b0;
         out_n  = 1'b0;
         ph_n   = PH_IDLE;
         cnt_n  = init_i;
      end else if (sw_start_i) begin
         run_n  = 1'b1;
         done_n = 1'b0;
         out_n  = 1'b0;
         case (ctrl_i.mode)
            M_GATED, M_CONT:  begin ph_n = PH_DELAY; cnt_n = dly_i; end
            M_TRIG, M_RETRIG: begin ph_n = PH_WAIT;  cnt_n = dly_i; end
            default:          begin ph_n = PH_IDLE;  cnt_n = init_i; end
         endcase
      end else if (run_q) begin
         case (ctrl_i.mode)
            M_EVENT:
               if (clk_edge_i && gate_lvl_i)
                  cnt_n = updown_i ? cnt_q + ONE : cnt_q - ONE;
            M_MEAS:
               if (!done_q) begin
                  if (gate_fall_i) done_n = 1'b1;
                  else if (clk_edge_i && gate_lvl_i)
                     cnt_n = updown_i ? cnt_q + ONE : cnt_q - ONE;
               end
            M_GATED, M_CONT:
               adv = clk_edge_i && gate_lvl_i;
            M_TRIG, M_RETRIG:
               if (ph_q == PH_WAIT) begin
                  if (gate_rise_i) begin
                     ph_n  = PH_DELAY;
                     cnt_n = dly_i;
                  end
               end else begin
                  adv = clk_edge_i;
               end
            default: ;
         endcase
      end
      if (adv) begin
         if (ph_q == PH_DELAY) begin
            if (cnt_q <= ONE) begin
               ph_n  = PH_WIDTH;
               cnt_n = wid_i;
               out_n = 1'b1;
            end else begin
               cnt_n = cnt_q - ONE;
            end
         end else if (ph_q == PH_WIDTH) begin
            if (cnt_q <= ONE) begin
               out_n = 1'b0;
               if (ctrl_i.mode == M_CONT) begin
                  ph_n  = PH_DELAY;
                  cnt_n = dly_i;
               end else if (ctrl_i.mode == M_RETRIG) begin
                  ph_n  = PH_WAIT;
                  cnt_n = '0;
               end else begin
                  ph_n   = PH_FINAL;
                  cnt_n  = '0;
                  done_n = 1'b1;
               end
            end else begin
               cnt_n = cnt_q - ONE;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         ph_q   <= PH_IDLE;
         run_q  <= 1'b0;
         done_q <= 1'b0;
         out_q  <= 1'b0;
      end else begin
         cnt_q  <= cnt_n;
         ph_q   <= ph_n;
         run_q  <= run_n;
         done_q <= done_n;
         out_q  <= out_n;
      end
   end

   assign cnt_o     = cnt_q;
   assign out_lvl_o = out_q;
   assign done_o    = done_q;

   logic quiet;
   assign quiet = !sw_start_i && !sw_reset_i;

   assert_halt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q && quiet |=> $stable(cnt_q) && $stable(out_q));

   assert_event_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      run_q && quiet && ctrl_i.mode == M_EVENT && clk_edge_i && gate_lvl_i |=>
      ($past(updown_i) ? cnt_q == $past(cnt_q) + ONE : cnt_q == $past(cnt_q) - ONE));

   assert_meas_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
      run_q && quiet && ctrl_i.mode == M_MEAS && done_q |=> $stable(cnt_q) && done_q);

   assert_retrig_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
      run_q && quiet && ctrl_i.mode == M_RETRIG && !clk_edge_i &&
      (ph_q == PH_DELAY || ph_q == PH_WIDTH) |=> $stable(cnt_q) && $stable(ph_q));

   assert_gate_pause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      run_q && quiet && (ctrl_i.mode == M_CONT || ctrl_i.mode == M_GATED) && !gate_lvl_i
      |=> $stable(cnt_q) && $stable(out_q));
endmodule

// File: rtl/gated_timer.sv
module gated_timer
   import gtc_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ev_clk_i,
   input  logic         gate_i,
   input  logic         updown_i,
   input  logic         wr_en_i,
   input  logic [1:0]   wr_sel_i,
   input  logic [W-1:0] wr_data_i,
   input  logic         sw_start_i,
   input  logic         sw_reset_i,
   output logic [W-1:0] count_o,
   output logic         out_o,
   output logic         done_o
);
   localparam int N_IN   = 2;
   localparam int IDX_CK = 0;
   localparam int IDX_GT = 1;

   if (W < CTRL_BITS) begin : g_bad_width
      $error("gated_timer: W must hold the control word");
   end

   ctrl_t        ctrl;
   logic [W-1:0] init_v, dly_v, wid_v;
   logic [N_IN-1:0] lvl, rise, fall;
   logic         out_lvl;

   gtc_regs #(.W(W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
      .wr_data_i(wr_data_i), .ctrl_o(ctrl), .init_o(init_v), .dly_o(dly_v),
      .wid_o(wid_v)
   );

   gtc_cond #(.N(N_IN)) u_cond (
      .clk(clk), .rst_n(rst_n),
      .sig_i({gate_i, ev_clk_i}),
      .inv_i({ctrl.gate_low, ctrl.clk_fall}),
      .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
   );

   logic sig_unused;
   assign sig_unused = ^{lvl[IDX_CK], fall[IDX_CK]};

   gtc_core #(.W(W)) u_core (
      .clk(clk), .rst_n(rst_n), .ctrl_i(ctrl), .init_i(init_v),
      .dly_i(dly_v), .wid_i(wid_v),
      .clk_edge_i(rise[IDX_CK]), .gate_lvl_i(lvl[IDX_GT]),
      .gate_rise_i(rise[IDX_GT]), .gate_fall_i(fall[IDX_GT]),
      .updown_i(updown_i), .sw_start_i(sw_start_i), .sw_reset_i(sw_reset_i),
      .cnt_o(count_o), .out_lvl_o(out_lvl), .done_o(done_o)
   );

   assign out_o = out_lvl ^ ctrl.out_inv;

   assert_reset_pri_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sw_reset_i && sw_start_i && !wr_en_i |=> count_o == $past(init_v) && !done_o);
endmodule

// File: tb/gated_timer_bench.sv
`timescale 1ns/1ps
module gated_timer_bench;
   localparam int W = 16;
   localparam int MAX_CYC = 200000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ev_clk = 1'b0, gate = 1'b0, updown = 1'b1;
   logic wr_en = 1'b0;
   logic [1:0] wr_sel = '0;
   logic [W-1:0] wr_data = '0;
   logic sw_start = 1'b0, sw_reset = 1'b0;
   logic [W-1:0] count;
   logic out, done;

   always #2 clk = ~clk;

   gated_timer #(.W(W)) u_gated_timer (
      .clk(clk), .rst_n(rst_n), .ev_clk_i(ev_clk), .gate_i(gate),
      .updown_i(updown), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
      .wr_data_i(wr_data), .sw_start_i(sw_start), .sw_reset_i(sw_reset),
      .count_o(count), .out_o(out), .done_o(done)
   );

   int n_tests = 0, n_fail = 0, cycles = 0;
   bit finished = 1'b0;
   string cur_req = "R1";

   // behavioural reference state; phase: 0 idle 1 wait 2 delay 3 width 4 final
   logic [W-1:0] m_cnt, m_init, m_dly, m_wid;
   int  m_mode, m_ph;
   bit  m_run, m_done, m_out, m_cpol, m_gpol, m_opol, m_pc, m_pg;

   task automatic check(bit ok, string req, string what, int act, int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic model_reset();
      m_cnt = '0; m_init = '0; m_dly = '0; m_wid = '0;
      m_mode = 0; m_ph = 0; m_run = 0; m_done = 0; m_out = 0;
      m_cpol = 0; m_gpol = 0; m_opol = 0; m_pc = 0; m_pg = 0;
   endtask

   task automatic advance();
      if (m_ph == 2) begin
         if (m_cnt <= 1) begin m_ph = 3; m_cnt = m_wid; m_out = 1; end
         else m_cnt = m_cnt - 1'b1;
      end else if (m_ph == 3) begin
         if (m_cnt > 1) m_cnt = m_cnt - 1'b1;
         else begin
            m_out = 0;
            if (m_mode == 5) begin m_ph = 2; m_cnt = m_dly; end
            else if (m_mode == 4) begin m_ph = 1; m_cnt = '0; end
            else begin m_ph = 4; m_cnt = '0; m_done = 1; end
         end
      end
   endtask

   task automatic model_step();
      bit c, g, e, gr, gf;
      c = ev_clk ^ m_cpol;
      g = gate ^ m_gpol;
      e = c && !m_pc;
      gr = g && !m_pg;
      gf = !g && m_pg;
      m_pc = c;
      m_pg = g;
      if (sw_reset) begin
         m_run = 0; m_done = 0; m_out = 0; m_ph = 0; m_cnt = m_init;
      end else if (sw_start) begin
         m_run = 1; m_done = 0; m_out = 0;
         if (m_mode == 2 || m_mode == 5) begin m_ph = 2; m_cnt = m_dly; end
         else if (m_mode == 3 || m_mode == 4) begin m_ph = 1; m_cnt = m_dly; end
         else begin m_ph = 0; m_cnt = m_init; end
      end else if (m_run) begin
         case (m_mode)
            0: if (e && g) m_cnt = updown ? m_cnt + 1'b1 : m_cnt - 1'b1;
            1: if (!m_done) begin
                  if (gf) m_done = 1;
                  else if (e && g) m_cnt = updown ? m_cnt + 1'b1 : m_cnt - 1'b1;
               end
            2, 5: if (e && g) advance();
            3, 4: if (m_ph == 1) begin
                     if (gr) begin m_ph = 2; m_cnt = m_dly; end
                  end else if (e) advance();
            default: ;
         endcase
      end
      if (wr_en) begin
         case (wr_sel)
            2'd0: begin
               m_mode = int'(wr_data[2:0]); m_cpol = wr_data[3];
               m_gpol = wr_data[4]; m_opol = wr_data[5];
            end
            2'd1: m_init = wr_data;
            2'd2: m_dly = wr_data;
            default: m_wid = wr_data;
         endcase
      end
   endtask

   task automatic tick();
      model_step();
      @(posedge clk);
      #1;
      cycles++;
      check(count == m_cnt, cur_req, "count_o", int'(count), int'(m_cnt));
      check(out == (m_out ^ m_opol), cur_req, "out_o", int'(out), int'(m_out ^ m_opol));
      check(done == m_done, cur_req, "done_o", int'(done), int'(m_done));
   endtask

   task automatic wr(input logic [1:0] sel, input int data);
      wr_en = 1; wr_sel = sel; wr_data = W'(data);
      tick();
      wr_en = 0;
   endtask

   task automatic start();
      sw_start = 1; tick(); sw_start = 0;
   endtask

   task automatic swrst();
      sw_reset = 1; tick(); sw_reset = 0;
   endtask

   task automatic pulses(input int n);
      for (int i = 0; i < n; i++) begin
         ev_clk = !ev_clk; tick();
         ev_clk = !ev_clk; tick();
      end
   endtask

   task automatic setup(input int ctrl, input int init, input int dly, input int wid);
      swrst();
      wr(2'd1, init); wr(2'd2, dly); wr(2'd3, wid); wr(2'd0, ctrl);
      swrst();
   endtask

   initial begin : watchdog
      #(MAX_CYC * 4);
      if (!finished) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d cycles", MAX_CYC, cycles);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin : stim
      model_reset();
      repeat (3) @(posedge clk);
      #1;
      check(count == 0 && out == 0 && done == 0, "R1", "reset outputs",
            int'({count, out, done}), 0);
      rst_n = 1;
      cur_req = "R1";
      tick();

      // R2: no counting before start, sw reset loads init, reset beats start
      cur_req = "R2";
      gate = 1;
      wr(2'd1, 3);
      pulses(3);
      check(count == 0, "R2", "count before start", int'(count), 0);
      swrst();
      check(count == 3, "R2", "init after sw reset", int'(count), 3);
      start(); pulses(2);
      swrst(); pulses(2);
      check(count == 3, "R2", "halted after sw reset", int'(count), 3);
      sw_start = 1; sw_reset = 1; tick(); sw_start = 0; sw_reset = 0;
      pulses(2);
      check(count == 3, "R2", "reset beats start", int'(count), 3);

      // R3 + R10: event counting, direction, gate, wrap
      cur_req = "R3";
      setup(0, 5, 0, 0);
      check(count == 5, "R10", "init register written", int'(count), 5);
      updown = 1; start(); pulses(4);
      check(count == 9, "R3", "count up", int'(count), 9);
      gate = 0; tick(); pulses(3);
      check(count == 9, "R3", "gate low holds", int'(count), 9);
      gate = 1; updown = 0; tick(); pulses(2);
      check(count == 7, "R3", "count down", int'(count), 7);
      setup(0, 0, 0, 0);
      start(); pulses(1);
      check(count == 16'hFFFF, "R3", "wrap below zero", int'(count), 16'hFFFF);
      updown = 1; pulses(1);
      check(count == 0, "R3", "wrap above max", int'(count), 0);

      // R4: measurement
      cur_req = "R4";
      gate = 0; tick();
      setup(1, 10, 0, 0);
      start(); gate = 1; tick(); pulses(3);
      check(count == 13, "R4", "measured", int'(count), 13);
      gate = 0; tick();
      check(done == 1, "R4", "done on gate fall", int'(done), 1);
      gate = 1; tick(); pulses(2);
      check(count == 13, "R4", "frozen", int'(count), 13);

      // R5: single gated pulse, delay 2 width 4
      cur_req = "R5";
      setup(2, 0, 2, 4);
      start(); pulses(1);
      check(out == 0, "R5", "low in delay", int'(out), 0);
      pulses(1);
      check(out == 1, "R5", "high after delay", int'(out), 1);
      gate = 0; tick(); pulses(3);
      check(count == 4 && out == 1, "R5", "gate pause", int'(count), 4);
      gate = 1; tick(); pulses(3);
      check(out == 1, "R5", "still high", int'(out), 1);
      pulses(1);
      check(out == 0 && done == 1, "R5", "pulse end", int'({out, done}), 1);
      setup(2, 0, 0, 0);
      start(); pulses(1);
      check(out == 1, "R5", "zero delay acts as one", int'(out), 1);
      pulses(1);
      check(out == 0 && done == 1, "R5", "zero width acts as one", int'({out, done}), 1);

      // R6: single triggered pulse
      cur_req = "R6";
      gate = 0; tick();
      setup(3, 0, 1, 2);
      start(); pulses(2);
      check(out == 0, "R6", "no pulse before trigger", int'(out), 0);
      gate = 1; tick(); pulses(1);
      check(out == 1, "R6", "pulse after trigger", int'(out), 1);
      gate = 0; tick(); gate = 1; tick(); pulses(2);
      check(out == 0 && done == 1, "R6", "one shot done", int'({out, done}), 1);
      gate = 0; tick(); gate = 1; tick(); pulses(2);
      check(out == 0, "R6", "later trigger ignored", int'(out), 0);

      // R7: retriggered
      cur_req = "R7";
      gate = 0; tick();
      setup(4, 0, 1, 3);
      start(); gate = 1; tick(); pulses(1);
      check(out == 1, "R7", "first pulse", int'(out), 1);
      gate = 0; tick(); gate = 1; tick(); pulses(3);
      check(out == 0 && done == 0, "R7", "mid-pulse trigger ignored", int'({out, done}), 0);
      gate = 0; tick(); gate = 1; tick(); pulses(1);
      check(out == 1, "R7", "second pulse", int'(out), 1);

      // R8: continuous
      cur_req = "R8";
      setup(5, 0, 2, 1);
      start(); pulses(2);
      check(out == 1, "R8", "first period", int'(out), 1);
      pulses(1);
      check(out == 0 && count == 2, "R8", "delay reloaded", int'(count), 2);
      pulses(2);
      check(out == 1, "R8", "second period", int'(out), 1);
      gate = 0; tick(); pulses(3);
      check(out == 1, "R8", "gate halt", int'(out), 1);
      gate = 1; tick(); pulses(1);
      check(out == 0, "R8", "resumes", int'(out), 0);

      // R9: falling clk, active-low gate, inverted out
      cur_req = "R9";
      ev_clk = 1; gate = 0; tick();
      setup(58, 0, 1, 2);
      start();
      check(out == 1, "R9", "inverted idle", int'(out), 1);
      pulses(1);
      check(out == 0, "R9", "falling edge counted", int'(out), 0);
      gate = 1; tick(); pulses(2);
      check(count == 2, "R9", "active-low gate pauses", int'(count), 2);
      gate = 0; tick(); pulses(2);
      check(out == 1 && done == 1, "R9", "end inverted", int'({out, done}), 3);

      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule